// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a 16-bit timer driven by a slow tick enable, nominally 32.768 kHz, which a programmable prescaler divides by 1, 16 or 256. In its general-purpose mode it counts up or down while a run bit is set. Each time it wraps, it reloads from a software load value and raises an interrupt. Software can switch it into a watchdog mode. In that mode it counts down from the load value and must be serviced before it reaches zero. A control bit decides what happens on expiry: an interrupt with automatic reload, or a reset request that stays high until the system reset arrives.

Software reaches the block through a small register port with four word slots. Writing any value to the service slot restarts the watchdog timeout and clears the interrupt. When watchdog mode starts, the load and control registers lock. Further writes to them are dropped until the next reset, so runaway code cannot turn the watchdog off or stretch its timeout. With a full-scale load and divide-by-256, the longest timeout is about 512 seconds. The system reset itself is outside the block. The block only raises the request.

Top module: `wdt_lock_timer`

## Requirements
- R1: Register slots are selected by a 2-bit address: 0 = load (read/write), 1 = current count (read-only; writes to it have no effect), 2 = control (read/write), 3 = service (write-only, reads as 0). The control fields are [1:0] prescale select, [2] count up, [3] run, [5] watchdog enable and [6] expiry action. Bits 4 and 7 read as 0.
- R2: After reset, load reads 0x0000, count reads 0xFFFF, control reads 0x0000, and both irq and rst_req are low.
- R3: Prescale select 0 divides the tick by 1 and select 1 divides it by 16. Selects 2 and 3 both divide it by 256. The counter moves one step per divided tick while it is active. The prescaler restarts whenever the counter is reloaded by a register write.
- R4: In general mode with run set, the counter decrements, or increments when count up is set. On a step from 0 (down) or from 0xFFFF (up), it reloads from the load register and sets irq. A load write in this mode also loads the counter with the written value.
- R5: A control write with bit 5 set, made while unlocked, enters watchdog mode. The counter loads from the load register on that same write. From then on it counts down, whatever bits 2 and 3 hold.
- R6: Once in watchdog mode, writes to load and control are ignored, and the mode persists until reset.
- R7: In watchdog mode, a service write reloads the counter from the load register and restarts the prescaler.
- R8: In watchdog mode with bit 6 = 0, a step from 0 sets irq and reloads the counter from the load register.
- R9: In watchdog mode with bit 6 = 1, a step from 0 raises rst_req. rst_req then stays high until reset, the counter holds 0, and service writes do not lower it.
- R10: irq stays high until a service write clears it, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow time-base enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register slot for the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Register slot for the combinational read |
| rd_data | output | 16 | Read data |
| irq | output | 1 | Interrupt, level, held until serviced |
| rst_req | output | 1 | Reset request, held until reset |

## Verification
The assertions check on every cycle the properties that are invariants of the state. The lock and the load value stay frozen in watchdog mode. The reset request stays high, and the counter holds zero while it does. The interrupt persists until serviced. A service write in watchdog mode reloads the counter and clears the interrupt. The exact step timing under each divide ratio, the wrap points in both directions, and the expiry latency in each action mode can only be shown by the bench scenarios. The bench compares them cycle by cycle against its behavioural model and counts the edges to each expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic [1:0] {
      SLOT_LOAD  = 2'd0,
      SLOT_COUNT = 2'd1,
      SLOT_CTRL  = 2'd2,
      SLOT_KICK  = 2'd3
   } slot_e;

   // control word layout, bit 0 at the bottom
   typedef struct packed {
      logic       rsv7;
      logic       exp_rst;
      logic       wd_on;
      logic       rsv4;
      logic       run;
      logic       up;
      logic [1:0] psel;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   function automatic ctrl_t ctrl_clean(input logic [CTRL_W-1:0] raw);
      ctrl_t c;
      c      = ctrl_t'(raw);
      c.rsv7 = 1'b0;
      c.rsv4 = 1'b0;
      return c;
   endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] load_q,
   output ctrl_t            ctrl_q,
   output logic             ld_wr,
   output logic             wd_enter,
   output logic             kick_wr
);

   logic  locked;
   logic  ctrl_wr;
   slot_e slot;
   ctrl_t ctrl_new;

   assign slot     = slot_e'(wr_addr);
   assign locked   = ctrl_q.wd_on;
   assign ctrl_new = ctrl_clean(wr_data[CTRL_W-1:0]);

   // R6: load and control writes are gated by the lock
   assign ld_wr    = wr_en && (slot == SLOT_LOAD) && !locked;
   assign ctrl_wr  = wr_en && (slot == SLOT_CTRL) && !locked;
   // R5: entry happens on an unlocked control write with the enable set
   assign wd_enter = ctrl_wr && ctrl_new.wd_on;
   assign kick_wr  = wr_en && (slot == SLOT_KICK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
         ctrl_q <= '0;
      end else begin
         if (ld_wr)   load_q <= wr_data;
         if (ctrl_wr) ctrl_q <= ctrl_new;
      end
   end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int DIV_A = 1,
   parameter int DIV_B = 16,
   parameter int DIV_C = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       active,
   input  logic       restart,
   input  logic [1:0] psel,
   output logic       step
);

   generate
      if (DIV_C == 1) begin : g_bypass
         // every ratio is 1: no state needed
         assign step = tick & active;
      end else begin : g_count
         localparam int PRE_W = $clog2(DIV_C);
         localparam logic [PRE_W-1:0] LIM_A = PRE_W'(DIV_A - 1);
         localparam logic [PRE_W-1:0] LIM_B = PRE_W'(DIV_B - 1);
         localparam logic [PRE_W-1:0] LIM_C = PRE_W'(DIV_C - 1);

         logic [PRE_W-1:0] pcnt;
         logic [PRE_W-1:0] lim;

         // R3: select 2 and 3 share the largest ratio
         always_comb begin
            unique case (psel)
               2'd0:    lim = LIM_A;
               2'd1:    lim = LIM_B;
               default: lim = LIM_C;
            endcase
         end

         // >= keeps a shrunk ratio from waiting for a full wrap
         assign step = tick & active & (pcnt >= lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pcnt <= '0;
            end else if (restart) begin
               pcnt <= '0;
            end else if (tick && active) begin
               pcnt <= step ? '0 : pcnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W = 16,
   parameter bit UP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             wd_mode,
   input  logic             up_sel,
   input  logic             exp_rst,
   input  logic             ld_wr,
   input  logic             wd_enter,
   input  logic             kick_wr,
   input  logic [CNT_W-1:0] load_q,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_q,
   output logic             irq,
   output logic             rst_req
);

   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic             going_up;
   logic             at_end;
   logic             irq_set;
   logic             rst_set;
   logic [CNT_W-1:0] cnt_nxt;

   generate
      if (UP_EN) begin : g_updown
         // R4: direction only matters outside watchdog mode
         assign going_up = up_sel & ~wd_mode;
      end else begin : g_down
         assign going_up = 1'b0;
      end
   endgenerate

   assign at_end = going_up ? (cnt_q == CNT_TOP) : (cnt_q == '0);

   always_comb begin
      cnt_nxt = cnt_q;
      irq_set = 1'b0;
      rst_set = 1'b0;
      if (rst_req) begin
         cnt_nxt = cnt_q;                       // R9 frozen
      end else if (ld_wr) begin
         cnt_nxt = wr_data;                     // R4
      end else if (wd_enter || (kick_wr && wd_mode)) begin
         cnt_nxt = load_q;                      // R5, R7
      end else if (step) begin
         if (at_end) begin
            if (wd_mode && exp_rst) begin
               rst_set = 1'b1;                  // R9
            end else begin
               cnt_nxt = load_q;                // R4, R8
               irq_set = 1'b1;
            end
         end else begin
            cnt_nxt = going_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= CNT_TOP;
         irq     <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         cnt_q   <= cnt_nxt;
         irq     <= (irq & ~kick_wr) | irq_set;   // R10
         rst_req <= rst_req | rst_set;
      end
   end

endmodule

// File: rtl/wdt_lock_timer.sv
module wdt_lock_timer
   import wdt_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int DIV_A = 1,
   parameter int DIV_B = 16,
   parameter int DIV_C = 256,
   parameter bit UP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   output logic             irq,
   output logic             rst_req
);

   localparam int PAD_W = CNT_W - CTRL_W;

   generate
      if (CNT_W <= CTRL_W || CNT_W > 32) begin : g_bad_width
         $error("wdt_lock_timer: CNT_W must exceed the control width and be at most 32");
      end
      if (DIV_A < 1 || DIV_B < DIV_A || DIV_C < DIV_B) begin : g_bad_div
         $error("wdt_lock_timer: dividers must be ascending and at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] load_q;
   logic [CNT_W-1:0] cnt_q;
   ctrl_t            ctrl_q;
   logic             ld_wr;
   logic             wd_enter;
   logic             kick_wr;
   logic             wd_locked;
   logic             active;
   logic             restart;
   logic             step;

   assign wd_locked = ctrl_q.wd_on;
   assign active    = wd_locked | ctrl_q.run;
   // R3: any reload by register write restarts the prescaler
   assign restart   = ld_wr | wd_enter | (kick_wr & wd_locked);

   wdt_regs #(.CNT_W(CNT_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .load_q   (load_q),
      .ctrl_q   (ctrl_q),
      .ld_wr    (ld_wr),
      .wd_enter (wd_enter),
      .kick_wr  (kick_wr)
   );

   wdt_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) pre_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .active  (active),
      .restart (restart),
      .psel    (ctrl_q.psel),
      .step    (step)
   );

   wdt_counter #(.CNT_W(CNT_W), .UP_EN(UP_EN)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .wd_mode  (wd_locked),
      .up_sel   (ctrl_q.up),
      .exp_rst  (ctrl_q.exp_rst),
      .ld_wr    (ld_wr),
      .wd_enter (wd_enter),
      .kick_wr  (kick_wr),
      .load_q   (load_q),
      .wr_data  (wr_data),
      .cnt_q    (cnt_q),
      .irq      (irq),
      .rst_req  (rst_req)
   );

   // R1: read map, count slot read-only, service slot reads 0
   always_comb begin
      unique case (slot_e'(rd_addr))
         SLOT_LOAD:  rd_data = load_q;
         SLOT_COUNT: rd_data = cnt_q;
         SLOT_CTRL:  rd_data = {{PAD_W{1'b0}}, ctrl_q};
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/wdt_lock_timer_chk.sv
module wdt_lock_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic             irq,
   input logic             rst_req,
   input logic             wd_locked,
   input logic [CNT_W-1:0] load_q,
   input logic [CNT_W-1:0] cnt_q
);

   logic kick;
   assign kick = wr_en && (wr_addr == 2'd3);

   // R9
   rst_req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> rst_req);

   // R9
   rst_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cnt_q == '0));

   // R9
   rst_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> wd_locked);

   // R6
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_locked |=> wd_locked);

   // R6
   load_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_locked |=> $stable(load_q));

   // R10
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !kick) |=> irq);

   // R7
   kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_locked && !rst_req && kick) |=> (cnt_q == $past(load_q)));

   // R7
   kick_irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_locked && kick) |=> !irq);

endmodule

bind wdt_lock_timer wdt_lock_timer_chk #(.CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .irq       (irq),
   .rst_req   (rst_req),
   .wd_locked (wd_locked),
   .load_q    (load_q),
   .cnt_q     (cnt_q)
);

// File: tb/wdt_lock_timer_tb.sv
module wdt_lock_timer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic [1:0]  rd_addr = 2'd1;
   logic [15:0] rd_data;
   logic        irq;
   logic        rst_req;

   int total = 0;
   int bad = 0;
   int tick_per = 0;
   int tcnt = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdt_lock_timer dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .irq     (irq),
      .rst_req (rst_req)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_load, m_cnt, m_ctrl, m_pre;
   bit m_irq, m_rst;

   always @(posedge clk) begin
      int  div;
      bit  lk, act, stp, rs, is_set, up;
      if (!rst_n) begin
         m_load = 0; m_cnt = 'hFFFF; m_ctrl = 0; m_pre = 0;
         m_irq = 0; m_rst = 0;
      end else begin
         lk  = m_ctrl[5];
         act = lk || m_ctrl[3];
         div = (m_ctrl[1:0] == 0) ? 1 : (m_ctrl[1:0] == 1) ? 16 : 256;
         stp = tick && act && (m_pre >= div - 1);
         rs  = (wr_en && wr_addr == 0 && !lk) ||
               (wr_en && wr_addr == 2 && !lk && wr_data[5]) ||
               (wr_en && wr_addr == 3 && lk);
         if (rs) m_pre = 0;
         else if (tick && act) m_pre = stp ? 0 : m_pre + 1;
         is_set = 0;
         up = m_ctrl[2] && !lk;
         if (m_rst) begin
         end else if (wr_en && wr_addr == 0 && !lk) m_cnt = wr_data;
         else if ((wr_en && wr_addr == 2 && !lk && wr_data[5]) ||
                  (wr_en && wr_addr == 3 && lk)) m_cnt = m_load;
         else if (stp) begin
            if (!up && m_cnt == 0) begin
               if (lk && m_ctrl[6]) m_rst = 1;
               else begin m_cnt = m_load; is_set = 1; end
            end else if (up && m_cnt == 'hFFFF) begin
               m_cnt = m_load; is_set = 1;
            end else m_cnt = up ? m_cnt + 1 : m_cnt - 1;
         end
         m_irq = (m_irq && !(wr_en && wr_addr == 3)) || is_set;
         if (wr_en && !lk && wr_addr == 0) m_load = wr_data;
         if (wr_en && !lk && wr_addr == 2) m_ctrl = wr_data & 'h6F;
      end
   end

   function automatic int m_read(input logic [1:0] a);
      case (a)
         2'd0:    return m_load;
         2'd1:    return m_cnt;
         2'd2:    return m_ctrl;
         default: return 0;
      endcase
   endfunction

   // per-cycle comparison away from the clock edge
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk("R4/R6/R1", "model read data", rd_data, m_read(rd_addr));
         chk("R10", "model irq", irq, m_irq);
         chk("R9", "model rst_req", rst_req, m_rst);
      end
   end

   // tick generator
   initial forever begin
      @(negedge clk);
      tcnt++;
      tick <= (tick_per > 0) && (tcnt % tick_per == 0);
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en <= 1'b1; wr_addr <= a; wr_data <= d;
      @(negedge clk);
      wr_en <= 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      @(negedge clk);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      while (!irq && n < 2000) begin @(negedge clk); n++; end
   endtask

   task automatic do_reset();
      @(negedge clk);
      wr_en <= 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic stop_and_clear();
      tick_per = 0;
      wr(2'd2, 16'h0000);
      wr(2'd3, 16'h0000);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL all: watchdog expired");
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      int n;
      do_reset();

      // R2 reset values, R1 service slot reads 0
      rd(2'd0, v); chk("R2", "load after reset", v, 16'h0000);
      rd(2'd1, v); chk("R2", "count after reset", v, 16'hFFFF);
      rd(2'd2, v); chk("R2", "control after reset", v, 16'h0000);
      rd(2'd3, v); chk("R1", "service slot read", v, 16'h0000);
      chk("R2", "irq after reset", irq, 1'b0);
      chk("R2", "rst_req after reset", rst_req, 1'b0);

      // R1 count slot is read-only
      wr(2'd1, 16'h1234);
      rd(2'd1, v); chk("R1", "count after write to it", v, 16'hFFFF);
      wr(2'd2, 16'hFF9C);
      rd(2'd2, v); chk("R1", "control reserved bits", v, 16'h000C);
      wr(2'd2, 16'h0000);

      // R4 down counting, divide by 1
      wr(2'd0, 16'd5);
      rd(2'd1, v); chk("R4", "load write loads counter", v, 16'd5);
      rd_addr = 2'd1;
      tick_per = 1;
      wr(2'd2, 16'h0008);
      wait_irq(n);
      chk("R4", "down expiry edges", n, 6);
      chk("R4", "reload after down expiry", rd_data, 16'd5);
      tick_per = 0;
      wr(2'd2, 16'h0000);
      repeat (3) @(negedge clk);
      chk("R10", "irq held without service", irq, 1'b1);
      wr(2'd3, 16'h0000);
      chk("R10", "irq cleared by service", irq, 1'b0);

      // R4 up counting
      wr(2'd0, 16'hFFFD);
      rd_addr = 2'd1;
      tick_per = 1;
      wr(2'd2, 16'h000C);
      wait_irq(n);
      chk("R4", "up expiry edges", n, 3);
      chk("R4", "reload after up wrap", rd_data, 16'hFFFD);
      stop_and_clear();

      // R3 divide by 16
      wr(2'd0, 16'd3);
      tick_per = 1;
      wr(2'd2, 16'h0009);
      wait_irq(n);
      chk("R3", "divide-by-16 expiry edges", n, 64);
      stop_and_clear();

      // R3 divide by 256, select 2 and alias 3
      wr(2'd0, 16'd0);
      tick_per = 1;
      wr(2'd2, 16'h000A);
      wait_irq(n);
      chk("R3", "divide-by-256 expiry edges", n, 256);
      stop_and_clear();
      wr(2'd0, 16'd0);
      tick_per = 1;
      wr(2'd2, 16'h000B);
      wait_irq(n);
      chk("R3", "select 3 aliases 256", n, 256);
      stop_and_clear();

      // R5 enter watchdog, R8 interrupt action
      wr(2'd0, 16'd9);
      wr(2'd1, 16'd0);
      wr(2'd0, 16'd4);
      rd_addr = 2'd1;
      tick_per = 1;
      wr(2'd2, 16'h0024);
      #1;
      chk("R5", "count loaded on entry", rd_data, 16'd4);
      wait_irq(n);
      chk("R8", "watchdog irq expiry edges", n, 5);
      chk("R8", "reload after watchdog irq", rd_data, 16'd4);

      // R6 lock
      tick_per = 0;
      wr(2'd0, 16'h0100);
      wr(2'd2, 16'h0000);
      rd(2'd0, v); chk("R6", "load locked", v, 16'd4);
      rd(2'd2, v); chk("R6", "control locked", v, 16'h0024);

      // R7 service reload
      tick_per = 1;
      repeat (2) @(negedge clk);
      rd_addr = 2'd1;
      wr(2'd3, 16'hABCD);
      #1;
      chk("R7", "service reloads count", rd_data, 16'd4);
      chk("R7", "service clears irq", irq, 1'b0);

      // R9 reset action
      do_reset();
      wr(2'd0, 16'd2);
      tick_per = 1;
      wr(2'd2, 16'h0060);
      n = 0;
      while (!rst_req && n < 2000) begin @(negedge clk); n++; end
      chk("R9", "reset request edges", n, 3);
      repeat (10) @(negedge clk);
      rd_addr = 2'd1; #1;
      chk("R9", "rst_req held", rst_req, 1'b1);
      chk("R9", "count held at zero", rd_data, 16'd0);
      wr(2'd3, 16'h0000);
      chk("R9", "service does not drop rst_req", rst_req, 1'b1);

      // R2 reset restores defaults
      tick_per = 0;
      do_reset();
      rd(2'd2, v); chk("R2", "control after second reset", v, 16'h0000);
      rd(2'd1, v); chk("R2", "count after second reset", v, 16'hFFFF);
      chk("R2", "rst_req after second reset", rst_req, 1'b0);

      // mixed traffic against the model
      tick_per = 3;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         rd_addr <= 2'($urandom % 4);
         if ($urandom % 6 == 0) begin
            logic [1:0]  a;
            logic [15:0] d;
            a = 2'($urandom % 4);
            d = 16'($urandom);
            if (a == 2'd0) d = 16'($urandom % 40);
            if (a == 2'd2 && ($urandom % 4 != 0)) d[5] = 1'b0;
            wr_en <= 1'b1; wr_addr <= a; wr_data <= d;
         end else begin
            wr_en <= 1'b0;
         end
         if (i % 500 == 499) do_reset();
      end
      @(negedge clk);
      wr_en <= 1'b0;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule